// File: doc/BRIEF.md
# UART Modem-Status and Autoflow Controller

This block holds the modem-handshake and interrupt logic of a 16550-class UART. It synchronises the active-low clear-to-send pin and reports its level and any change of level in a modem status register. It drives the active-low request-to-send pin from a modem control register. It gates the start of each transmitted character when automatic CTS flow control is on. It merges four interrupt sources into one active-high request, with a fixed-priority identification code.

A CPU reaches the registers through a byte port. An access needs chip select low plus a low read or write strobe, and a 3-bit address picks the register. Each clock edge with an access in progress counts as one access. The serialiser, deserialiser, FIFOs and baud generator sit outside the block. They appear only as status inputs: receive error, receive data ready, receive-threshold reached, holding-register empty, character in progress and start request.

Register map (address: content):
- 1: interrupt enable. bit0 = receive data, bit1 = holding empty, bit2 = receive error, bit3 = modem status.
- 2: interrupt identification (read only).
- 4: modem control. bit1 = RTS request, bit4 = loopback, bit5 = automatic CTS, bit6 = automatic RTS.
- 6: modem status (read only). bit4 = CTS active, bit0 = CTS changed.

All other addresses read as zero.

Top module: `uart_mdm_ctrl`

## Requirements
- R1: Modem status bit4 equals the inverse of `cts_ni` after a two-flop synchroniser. It is still the old value one clock edge after the pin changes, shows the new value after the second edge, and reads 0 after reset with the pin high.
- R2: Modem status bit0 is set one edge after the synchronised CTS changes level. A modem status read clears it at that edge. A change that lands on the same edge as the read stays set for the next read.
- R3: A set CTS-change bit requests an interrupt only when enable bit3 is set and automatic CTS (control bit5) is clear. The change bit itself is recorded in either mode.
- R4: `tx_start_o` = `tx_req_i` and not `tx_busy_i` and (CTS active or automatic CTS off). A character already in progress is not affected.
- R5: `rts_no` is low only when control bit1 is set, loopback (bit4) is clear, and automatic RTS (bit6) is not combined with `rx_thr_i` high. Otherwise it is high.
- R6: `irq_o` is the OR of the enabled pending sources: `rx_err_i` (enable bit2), `rx_avail_i` (bit0), holding-empty pending (bit1) and modem (bit3). With enable = 0 it stays low.
- R7: The identification register reads {4'b0, code, none}, with none = 1 when nothing is pending. Codes by priority are: error 3 (0x06), receive data 2 (0x04), holding empty 1 (0x02), modem 0 (0x00). Idle reads 0x01.
- R8: Holding-empty pending sets on a rising edge of `thr_empty_i`. It clears when the identification register is read while reporting code 1, or when `thr_empty_i` is low.
- R9: Writes with `cs_ni` high change nothing. `rdata_o` is 0 whenever no read access is active.
- R10: Reset (`rst_ni` low) clears every register, drives `rts_no` high, and drives `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| cs_ni | input | 1 | chip select, active low |
| rd_ni | input | 1 | read strobe, active low |
| wr_ni | input | 1 | write strobe, active low |
| addr_i | input | 3 | register address |
| wdata_i | input | 8 | write data |
| rdata_o | output | 8 | read data, 0 when idle |
| cts_ni | input | 1 | clear-to-send pin, active low |
| rts_no | output | 1 | request-to-send pin, active low |
| rx_err_i | input | 1 | receive line error pending |
| rx_avail_i | input | 1 | receive data ready or timeout |
| rx_thr_i | input | 1 | receive FIFO at threshold |
| thr_empty_i | input | 1 | transmit holding register empty |
| tx_busy_i | input | 1 | character being shifted out |
| tx_req_i | input | 1 | serialiser wants to start a character |
| tx_start_o | output | 1 | start permitted |
| irq_o | output | 1 | interrupt request, active high |

## Verification
The bench reads the status register on the exact edges around a CTS change. A change bit that is lost on a coincident read, or a status bit that skips a synchroniser stage, shows up as a wrong value in one of those reads. It sweeps all sixteen combinations of interrupt sources. A priority error or a source that is not ORed in gives a wrong identification code or interrupt level. Exhaustive sweeps over the RTS and transmit-start inputs catch an RTS that ignores loopback or the threshold, and a start gate that leaks while CTS is inactive. It also confirms that automatic CTS mode suppresses the modem interrupt but still records the change bit.

// File: rtl/uart_mdm_pkg.sv
package uart_mdm_pkg;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int NSRC = 4;

  localparam logic [AW-1:0] A_IER = 3'd1;
  localparam logic [AW-1:0] A_IIR = 3'd2;
  localparam logic [AW-1:0] A_MCR = 3'd4;
  localparam logic [AW-1:0] A_MSR = 3'd6;

  localparam int MCR_RTS  = 1;
  localparam int MCR_LOOP = 4;
  localparam int MCR_ACTS = 5;
  localparam int MCR_ARTS = 6;

  // source index order in the arbiter vector, low index = low priority
  localparam int S_MDM = 0;
  localparam int S_THR = 1;
  localparam int S_RXD = 2;
  localparam int S_RLS = 3;

  typedef enum logic [2:0] {
    ID_MDM = 3'd0,
    ID_THR = 3'd1,
    ID_RXD = 3'd2,
    ID_RLS = 3'd3
  } irq_id_e;
endpackage

// File: rtl/uart_cts_track.sv
module uart_cts_track #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cts_ni,
  input  logic clr_i,
  output logic cts_o,
  output logic dcts_o
);
  logic [STAGES-1:0] sync_q;
  logic cts_q, chg;

  assign cts_o = ~sync_q[STAGES-1];
  assign chg   = cts_o ^ cts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      cts_q  <= 1'b0;
      dcts_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], cts_ni};
      cts_q  <= cts_o;
      // a change on the clearing edge survives for the next read
      dcts_o <= clr_i ? chg : (dcts_o | chg);
    end
  end

  AST_DCTS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni) chg |=> dcts_o); // R2
  AST_DCTS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni) (clr_i && !chg) |=> !dcts_o); // R2
endmodule

// File: rtl/uart_flow_gate.sv
module uart_flow_gate (
  input  logic rts_bit_i,
  input  logic loop_i,
  input  logic auto_rts_i,
  input  logic auto_cts_i,
  input  logic rx_thr_i,
  input  logic cts_i,
  input  logic tx_busy_i,
  input  logic tx_req_i,
  output logic rts_no,
  output logic tx_start_o
);
  logic rts_act;

  assign rts_act    = rts_bit_i & ~loop_i & ~(auto_rts_i & rx_thr_i);
  assign rts_no     = ~rts_act;
  // only the start of a new character is held back
  assign tx_start_o = tx_req_i & ~tx_busy_i & (cts_i | ~auto_cts_i);
endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb
  import uart_mdm_pkg::*;
(
  input  logic [NSRC-1:0] src_i,
  output logic            irq_o,
  output logic [3:0]      iir_o
);
  irq_id_e id;

  always_comb begin
    id = ID_MDM;
    if      (src_i[S_RLS]) id = ID_RLS;
    else if (src_i[S_RXD]) id = ID_RXD;
    else if (src_i[S_THR]) id = ID_THR;
  end

  assign irq_o = |src_i;
  assign iir_o = {id, ~irq_o};
endmodule

// File: rtl/uart_mdm_ctrl.sv
module uart_mdm_ctrl
  import uart_mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          cts_ni,
  output logic          rts_no,
  input  logic          rx_err_i,
  input  logic          rx_avail_i,
  input  logic          rx_thr_i,
  input  logic          thr_empty_i,
  input  logic          tx_busy_i,
  input  logic          tx_req_i,
  output logic          tx_start_o,
  output logic          irq_o
);
  logic [3:0]      ier_q;
  logic [DW-1:0]   mcr_q;
  logic            thr_pend_q, thr_q;
  logic            rd_en, wr_en, msr_rd, iir_rd;
  logic            cts_act, dcts;
  logic [NSRC-1:0] src;
  logic [3:0]      iir;

  assign rd_en  = ~cs_ni & ~rd_ni;
  assign wr_en  = ~cs_ni & ~wr_ni;
  assign msr_rd = rd_en && addr_i == A_MSR;
  assign iir_rd = rd_en && addr_i == A_IIR;

  uart_cts_track #(.STAGES(SYNC_STAGES)) u_cts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cts_ni(cts_ni),
    .clr_i (msr_rd),
    .cts_o (cts_act),
    .dcts_o(dcts)
  );

  uart_flow_gate u_flow (
    .rts_bit_i (mcr_q[MCR_RTS]),
    .loop_i    (mcr_q[MCR_LOOP]),
    .auto_rts_i(mcr_q[MCR_ARTS]),
    .auto_cts_i(mcr_q[MCR_ACTS]),
    .rx_thr_i  (rx_thr_i),
    .cts_i     (cts_act),
    .tx_busy_i (tx_busy_i),
    .tx_req_i  (tx_req_i),
    .rts_no    (rts_no),
    .tx_start_o(tx_start_o)
  );

  assign src[S_RLS] = rx_err_i   & ier_q[2];
  assign src[S_RXD] = rx_avail_i & ier_q[0];
  assign src[S_THR] = thr_pend_q & ier_q[1];
  assign src[S_MDM] = dcts & ier_q[3] & ~mcr_q[MCR_ACTS];

  uart_irq_arb u_arb (
    .src_i(src),
    .irq_o(irq_o),
    .iir_o(iir)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_q      <= '0;
      mcr_q      <= '0;
      thr_pend_q <= 1'b0;
      thr_q      <= 1'b0;
    end else begin
      thr_q <= thr_empty_i;
      if (wr_en && addr_i == A_IER) ier_q <= wdata_i[3:0];
      if (wr_en && addr_i == A_MCR) mcr_q <= wdata_i;
      if (!thr_empty_i)                           thr_pend_q <= 1'b0;
      else if (!thr_q)                            thr_pend_q <= 1'b1;
      else if (iir_rd && iir == {ID_THR, 1'b0})   thr_pend_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      unique case (addr_i)
        A_IER:   rdata_o = {4'b0, ier_q};
        A_IIR:   rdata_o = {4'b0, iir};
        A_MCR:   rdata_o = mcr_q;
        A_MSR:   rdata_o = {3'b0, cts_act, 3'b0, dcts};
        default: rdata_o = '0;
      endcase
    end
  end

  AST_LOOP_RTS:   assert property (@(posedge clk_i) disable iff (!rst_ni) mcr_q[MCR_LOOP] |-> rts_no); // R5
  AST_CTS_HOLD:   assert property (@(posedge clk_i) disable iff (!rst_ni) (mcr_q[MCR_ACTS] && !cts_act) |-> !tx_start_o); // R4
  AST_MDM_QUIET:  assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (mcr_q[MCR_ACTS] && !rx_err_i && !rx_avail_i && !thr_pend_q) |-> !irq_o); // R3
  AST_IER_GATE:   assert property (@(posedge clk_i) disable iff (!rst_ni) (ier_q == 4'd0) |-> !irq_o); // R6
  AST_IRQ_ID:     assert property (@(posedge clk_i) disable iff (!rst_ni) irq_o |-> (rdata_o[0] == 1'b0 || !iir_rd)); // R7
  AST_THR_CLR:    assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (iir_rd && iir == {ID_THR, 1'b0}) |=> !thr_pend_q); // R8
endmodule

// File: tb/uart_mdm_ctrl_test.sv
module uart_mdm_ctrl_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic cts_ni = 1'b1;
  logic rts_no, tx_start_o, irq_o;
  logic rx_err_i = 0, rx_avail_i = 0, rx_thr_i = 0, thr_empty_i = 0, tx_busy_i = 0, tx_req_i = 0;
  int n_chk = 0, n_fail = 0;
  logic [7:0] d;

  always #2 clk = ~clk;

  uart_mdm_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .cts_ni(cts_ni),
    .rts_no(rts_no), .rx_err_i(rx_err_i), .rx_avail_i(rx_avail_i), .rx_thr_i(rx_thr_i),
    .thr_empty_i(thr_empty_i), .tx_busy_i(tx_busy_i), .tx_req_i(tx_req_i),
    .tx_start_o(tx_start_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    cts_ni = 1; rx_err_i = 0; rx_avail_i = 0; rx_thr_i = 0; thr_empty_i = 0;
    tx_busy_i = 0; tx_req_i = 0;
    rst_ni = 0; wait_n(2); rst_ni = 1; wait_n(1);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    cs_ni = 0; wr_ni = 0; addr_i = a; wdata_i = v;
    @(negedge clk);
    cs_ni = 1; wr_ni = 1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    cs_ni = 0; rd_ni = 0; addr_i = a;
    #1 v = rdata_o;
    @(negedge clk);
    cs_ni = 1; rd_ni = 1;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    wait_n(150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    do_reset();
    // R10 reset state
    chk("R10 rts", {7'b0, rts_no}, 8'h01);
    chk("R10 irq", {7'b0, irq_o}, 8'h00);
    rd(3'd6, d); chk("R10 msr", d, 8'h00);
    rd(3'd2, d); chk("R10 iir", d, 8'h01);
    rd(3'd4, d); chk("R10 mcr", d, 8'h00);

    // R9 unselected write ignored, idle read data zero
    cs_ni = 1; wr_ni = 0; addr_i = 3'd4; wdata_i = 8'h02; @(negedge clk); wr_ni = 1;
    rd(3'd4, d); chk("R9 mcr", d, 8'h00);
    chk("R9 rts", {7'b0, rts_no}, 8'h01);
    rd_ni = 0; addr_i = 3'd4; #1 chk("R9 idle rdata", rdata_o, 8'h00); @(negedge clk); rd_ni = 1;

    // R5 sweep: rts bit, loop, auto-rts, threshold
    for (int i = 0; i < 16; i++) begin
      logic r, l, a, t;
      {r, l, a, t} = 4'(i);
      wr(3'd4, {1'b0, a, 1'b0, l, 2'b0, r, 1'b0});
      rx_thr_i = t; #1;
      chk("R5 rts_no", {7'b0, rts_no}, {7'b0, ~(r & ~l & ~(a & t))});
      @(negedge clk);
    end
    rx_thr_i = 0;

    // R4 / R1 sweep: auto-cts, cts level, busy, request
    for (int i = 0; i < 16; i++) begin
      logic ac, c, b, q;
      {ac, c, b, q} = 4'(i);
      wr(3'd4, {2'b0, ac, 5'b0});
      cts_ni = ~c; wait_n(3);
      tx_busy_i = b; tx_req_i = q; #1;
      chk("R4 tx_start", {7'b0, tx_start_o}, {7'b0, q & ~b & (c | ~ac)});
      rd(3'd6, d); chk("R1 msr cts", {7'b0, d[4]}, {7'b0, c});
    end
    tx_busy_i = 0; tx_req_i = 0;

    // R1/R2 edge timing around a CTS change
    do_reset();
    cts_ni = 0; @(negedge clk);
    rd(3'd6, d); chk("R1 one edge", d, 8'h00);
    rd(3'd6, d); chk("R1 two edges", d, 8'h10);
    rd(3'd6, d); chk("R2 kept on coincident read", d, 8'h11);
    rd(3'd6, d); chk("R2 cleared by read", d, 8'h10);

    // R3 modem interrupt, then suppressed in auto-cts mode
    do_reset();
    wr(3'd1, 8'h08);
    cts_ni = 0; wait_n(4);
    chk("R3 irq", {7'b0, irq_o}, 8'h01);
    rd(3'd2, d); chk("R3 iir", d, 8'h00);
    rd(3'd6, d); chk("R3 msr", d, 8'h11);
    chk("R3 irq cleared", {7'b0, irq_o}, 8'h00);
    wr(3'd4, 8'h20);
    cts_ni = 1; wait_n(4);
    chk("R3 auto quiet", {7'b0, irq_o}, 8'h00);
    rd(3'd6, d); chk("R3 auto delta kept", d, 8'h01);

    // R6/R7 sweep of all source combinations
    for (int i = 0; i < 16; i++) begin
      logic e, x, t, m;
      logic [7:0] exp;
      {e, x, t, m} = 4'(i);
      do_reset();
      wr(3'd1, 8'h0F);
      if (m) begin cts_ni = 0; wait_n(4); end
      if (t) begin thr_empty_i = 1; wait_n(2); end
      rx_err_i = e; rx_avail_i = x; #1;
      exp = e ? 8'h06 : x ? 8'h04 : t ? 8'h02 : m ? 8'h00 : 8'h01;
      chk("R6 irq", {7'b0, irq_o}, {7'b0, |i[3:0]});
      rd(3'd2, d); chk("R7 iir", d, exp);
    end
    do_reset();
    cts_ni = 0; thr_empty_i = 1; rx_err_i = 1; rx_avail_i = 1; wait_n(4);
    chk("R6 masked irq", {7'b0, irq_o}, 8'h00);
    rd(3'd2, d); chk("R6 masked iir", d, 8'h01);

    // R8 holding-empty pending
    do_reset();
    wr(3'd1, 8'h02);
    thr_empty_i = 1; wait_n(2);
    chk("R8 set", {7'b0, irq_o}, 8'h01);
    rd(3'd2, d); chk("R8 iir", d, 8'h02);
    rd(3'd2, d); chk("R8 cleared by read", d, 8'h01);
    thr_empty_i = 0; wait_n(1); thr_empty_i = 1; wait_n(2);
    chk("R8 re-armed", {7'b0, irq_o}, 8'h01);
    thr_empty_i = 0; wait_n(2);
    chk("R8 cleared by fill", {7'b0, irq_o}, 8'h00);

    report();
  end
endmodule